// File: doc/BRIEF.md
# Three-Wire Serial RAM Target

This block is a 128-byte read/write memory that a host reaches over three wires: a transfer-enable line, a serial clock and one data line. The whole block runs on a fast system clock. The serial clock, the enable line and the incoming data are brought in through synchronizers, and edge detectors turn the serial clock into rise and fall strobes. Each transfer begins when the enable line goes high. The host then clocks in a 24-bit command made of three bytes, sent least-significant bit first. The first byte selects read or write. The second byte carries a 7-bit address. The third byte carries the burst flag. After the command, data bytes follow. Write data is sampled on serial-clock rises, and read data is driven on serial-clock falls.

A command byte that does not match its exact pattern puts the port into a locked state. The port then ignores all further activity until the enable line goes low and rises again. Setting the burst flag together with address zero selects burst mode, which transfers the whole array as 128 consecutive bytes. Without it, exactly one byte is transferred. The data line is modelled as a driven value `sdOut` with an enable `sdOe`, which the pad merges into one bidirectional wire.

Top module: `serial_ram_target`

## Requirements
- R1: After system reset, every byte of the array reads as 0x00 and `sdOe` is low.
- R2: The first command byte, assembled least-significant bit first, must be 0x9D (write) or 0x62 (read). Any other value locks the port: no data is driven and nothing is stored.
- R3: Bit 7 of the second command byte must be 0, otherwise the port locks. Bits 0 to 6 of that byte are the byte address.
- R4: Bits 0 to 6 of the third command byte must all be 0, otherwise the port locks. Bit 7 of that byte is the burst flag.
- R5: In a single-byte write, the eight serial-clock rises after the command sample one data byte, least-significant bit first. The byte is stored at the addressed location.
- R6: In a single-byte read, `sdOe` is high and `sdOut` carries the addressed byte, least-significant bit first, one bit per serial-clock fall, for the eight clocks after the command.
- R7: Serial clocks after a single-byte transfer are ignored. `sdOe` stays low and no further location is written.
- R8: A burst flag of 1 with address 0 transfers 128 consecutive bytes, starting at location 0, in both read and write. After the last byte, `sdOe` stays low.
- R9: A burst flag of 1 with a nonzero address gives an ordinary single-byte transfer at that address.
- R10: A write byte that is cut short by the enable line going low is discarded, and the location keeps its old value.
- R11: While the enable line is low, `sdOe` is low.
- R12: Once the port is locked, a valid command that follows it in the same transfer has no effect. A new transfer after the enable line falls and rises again works normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst_n | input | 1 | Active-low system reset |
| xferEn | input | 1 | Transfer enable from the host, active high, asynchronous |
| sclk | input | 1 | Serial clock from the host, asynchronous |
| sdIn | input | 1 | Data line value as seen by the target |
| sdOut | output | 1 | Value the target drives onto the data line |
| sdOe | output | 1 | Drive enable for the data line, high while the target is driving |

## Verification
The assertions rely on a few conditions at the inputs. Each serial-clock phase lasts several system clocks. The enable line changes only while the serial clock is steady, so an enable edge and a serial edge never meet in the same synchronized cycle. Incoming data is stable around every serial rise. The bench holds each serial half-period for eight system clocks. It raises the enable line with the serial clock low, lowers it with the serial clock high, and changes `sdIn` only together with a serial fall. A behavioural model of the array predicts the drive enable and the read bit at every serial clock.

// File: rtl/srt_pkg.sv
package srt_pkg;
  localparam int ADDR_W    = 7;
  localparam int BYTE_W    = 8;
  localparam int CMD_BYTES = 3;
  localparam int CMD_BITS  = CMD_BYTES * BYTE_W;
  localparam int DEPTH     = 1 << ADDR_W;
  localparam int BIT_W     = $clog2(BYTE_W);
  localparam int CNT_W     = $clog2(CMD_BITS);

  localparam logic [BYTE_W-1:0] WR_CODE = 8'h9D;
  localparam logic [BYTE_W-1:0] RD_CODE = 8'h62;

  typedef enum logic [1:0] {ST_IDLE, ST_CMD, ST_DATA, ST_HALT} srtState_e;

  typedef struct packed {
    logic              loadAddr;
    logic [ADDR_W-1:0] addr;
    logic              wrBit;
    logic              commit;
    logic              drive;
    logic [BIT_W-1:0]  bitSel;
    logic              advance;
    logic              oeOff;
  } srtStrobe_t;
endpackage

// File: rtl/srt_sync.sv
module srt_sync #(
  parameter int STAGES = 2,
  parameter int WIDTH  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);
  logic [WIDTH-1:0] stage [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stage[i] <= '0;
    end else begin
      stage[0] <= asyncIn;
      for (int i = 1; i < STAGES; i++) stage[i] <= stage[i-1];
    end
  end

  assign syncOut = stage[STAGES-1];
endmodule

// File: rtl/srt_ctrl.sv
module srt_ctrl
  import srt_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       enS,
  input  logic       sclkS,
  input  logic       dinS,
  output srtStrobe_t st
);
  localparam logic [CNT_W-1:0] LAST_CMD  = CNT_W'(CMD_BITS - 1);
  localparam logic [CNT_W-1:0] BYTE1_END = CNT_W'(BYTE_W - 1);
  localparam logic [CNT_W-1:0] ADDR_END  = CNT_W'(BYTE_W + ADDR_W - 1);
  localparam logic [CNT_W-1:0] B2_TOP    = CNT_W'(2 * BYTE_W - 1);
  localparam logic [CNT_W-1:0] B3_FIRST  = CNT_W'(2 * BYTE_W);

  srtState_e         state;
  logic [BYTE_W-1:0] byteSr;
  logic [CNT_W-1:0]  cmdCnt;
  logic [ADDR_W-1:0] addrReg;
  logic              isWrite, isBurst, sclkPrev;
  logic [BIT_W-1:0]  dataBit;
  logic [ADDR_W-1:0] byteCnt;

  logic              rise, fall, cmdBad, lastByte, endRise, burstNow;
  logic [BYTE_W-1:0] nxtB;

  assign rise     = sclkS & ~sclkPrev;
  assign fall     = ~sclkS & sclkPrev;
  assign nxtB     = {dinS, byteSr[BYTE_W-1:1]};
  assign burstNow = dinS && (addrReg == '0);
  assign lastByte = !isBurst || (&byteCnt);
  assign endRise  = (state == ST_DATA) && rise && (&dataBit);

  always_comb begin
    cmdBad = 1'b0;
    if (cmdCnt == BYTE1_END)
      cmdBad = (nxtB != WR_CODE) && (nxtB != RD_CODE);
    else if (cmdCnt == B2_TOP)
      cmdBad = dinS;
    else if (cmdCnt >= B3_FIRST && cmdCnt < LAST_CMD)
      cmdBad = dinS;
  end

  always_comb begin
    st          = '0;
    st.loadAddr = (state == ST_CMD) && rise && (cmdCnt == LAST_CMD) && !cmdBad;
    st.addr     = addrReg;
    st.wrBit    = (state == ST_DATA) && rise && isWrite;
    st.commit   = st.wrBit && (&dataBit);
    st.drive    = (state == ST_DATA) && fall && !isWrite;
    st.bitSel   = dataBit;
    st.advance  = endRise && isBurst;
    st.oeOff    = (state != ST_DATA) || (endRise && lastByte);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      byteSr   <= '0;
      cmdCnt   <= '0;
      addrReg  <= '0;
      isWrite  <= 1'b0;
      isBurst  <= 1'b0;
      dataBit  <= '0;
      byteCnt  <= '0;
      sclkPrev <= 1'b0;
    end else begin
      sclkPrev <= sclkS;
      if (!enS) begin
        state <= ST_IDLE;
      end else begin
        unique case (state)
          ST_IDLE: begin
            state  <= ST_CMD;
            cmdCnt <= '0;
          end
          ST_CMD: if (rise) begin
            byteSr <= nxtB;
            cmdCnt <= cmdCnt + 1'b1;
            if (cmdCnt == BYTE1_END) isWrite <= (nxtB == WR_CODE);
            if (cmdCnt == ADDR_END)  addrReg <= nxtB[BYTE_W-1 -: ADDR_W];
            if (cmdBad) begin
              state <= ST_HALT;
            end else if (cmdCnt == LAST_CMD) begin
              state   <= ST_DATA;
              isBurst <= burstNow;
              dataBit <= '0;
              byteCnt <= '0;
            end
          end
          ST_DATA: if (rise) begin
            dataBit <= dataBit + 1'b1;
            if (&dataBit) begin
              byteCnt <= byteCnt + 1'b1;
              if (lastByte) state <= ST_HALT;
            end
          end
          default: state <= ST_HALT;
        endcase
      end
    end
  end

  // R12
  halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_HALT && enS) |=> (state == ST_HALT));

  // R2
  cmd_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_CMD) |-> (cmdCnt <= LAST_CMD));

  // R11
  en_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enS |=> (state == ST_IDLE));
endmodule

// File: rtl/srt_dpath.sv
module srt_dpath
  import srt_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       dinS,
  input  srtStrobe_t st,
  output logic       outBit,
  output logic       oeReg
);
  logic [BYTE_W-1:0] mem [DEPTH];
  logic [ADDR_W-1:0] addr;
  logic [BYTE_W-1:0] wrSr;
  logic [BYTE_W-1:0] wrNext;

  assign wrNext = {dinS, wrSr[BYTE_W-1:1]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      addr   <= '0;
      wrSr   <= '0;
      oeReg  <= 1'b0;
      outBit <= 1'b0;
    end else begin
      if (st.loadAddr)     addr <= st.addr;
      else if (st.advance) addr <= addr + 1'b1;
      if (st.wrBit)  wrSr <= wrNext;
      if (st.commit) mem[addr] <= wrNext;
      if (st.drive) begin
        outBit <= mem[addr][st.bitSel];
        oeReg  <= 1'b1;
      end else if (st.oeOff) begin
        oeReg <= 1'b0;
      end
    end
  end

  // R5
  commit_no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st.commit |-> !oeReg);

  // R6
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({st.drive, st.commit, st.loadAddr}));

  // R7
  oe_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st.oeOff |=> !oeReg);
endmodule

// File: rtl/serial_ram_target.sv
module serial_ram_target
  import srt_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic xferEn,
  input  logic sclk,
  input  logic sdIn,
  output logic sdOut,
  output logic sdOe
);
  logic [2:0] syncV;
  srtStrobe_t strobes;
  logic       outBit, oeReg;

  srt_sync #(.STAGES(SYNC_STAGES), .WIDTH(3)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .asyncIn({xferEn, sclk, sdIn}),
    .syncOut(syncV)
  );

  srt_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .enS(syncV[2]), .sclkS(syncV[1]), .dinS(syncV[0]),
    .st(strobes)
  );

  srt_dpath u_dpath (
    .clk(clk), .rst_n(rst_n),
    .dinS(syncV[0]), .st(strobes),
    .outBit(outBit), .oeReg(oeReg)
  );

  assign sdOe  = oeReg & xferEn;
  assign sdOut = outBit & sdOe;
endmodule

// File: tb/serial_ram_target_bench.sv
module serial_ram_target_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic xferEn = 1'b0;
  logic sclk = 1'b0;
  logic sdIn = 1'b0;
  logic sdOut, sdOe;

  int errors = 0;
  int checks = 0;
  logic [7:0] model [128];

  always #5 clk = ~clk;

  serial_ram_target u_serial_ram_target (
    .clk(clk), .rst_n(rst_n), .xferEn(xferEn), .sclk(sclk),
    .sdIn(sdIn), .sdOut(sdOut), .sdOe(sdOe)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // R11: sampled every system clock
  always @(negedge clk) begin
    if (rst_n && !xferEn) chk(sdOe == 1'b0, "R11", "oe with enable low", sdOe, 0);
  end

  task automatic sbit(input logic d, output logic q, output logic oe);
    sclk = 1'b0;
    sdIn = d;
    repeat (8) @(posedge clk);
    #1;
    q  = sdOut;
    oe = sdOe;
    sclk = 1'b1;
    repeat (8) @(posedge clk);
    #1;
  endtask

  task automatic startX();
    sclk = 1'b0;
    xferEn = 1'b1;
    repeat (8) @(posedge clk);
    #1;
  endtask

  task automatic endX();
    xferEn = 1'b0;
    repeat (4) @(posedge clk);
    #1;
    chk(sdOe == 1'b0, "R11", "oe after end", sdOe, 0);
    repeat (4) @(posedge clk);
    #1;
  endtask

  task automatic dataBits(input logic [7:0] d, input int n, input bit expOe,
                          input logic [7:0] expQ, input string tag);
    logic q, oe;
    for (int i = 0; i < n; i++) begin
      sbit(d[i], q, oe);
      chk(oe == expOe, tag, "oe", oe, expOe);
      if (expOe) chk(q == expQ[i], tag, "read bit", q, expQ[i]);
    end
  endtask

  task automatic cmdOnly(input logic [7:0] b1, input logic [7:0] b2, input logic [7:0] b3);
    startX();
    dataBits(b1, 8, 1'b0, 8'h00, "R2");
    dataBits(b2, 8, 1'b0, 8'h00, "R3");
    dataBits(b3, 8, 1'b0, 8'h00, "R4");
  endtask

  task automatic writeByte(input logic [6:0] a, input logic [7:0] d);
    cmdOnly(8'h9D, {1'b0, a}, 8'h00);
    dataBits(d, 8, 1'b0, 8'h00, "R5");
    model[a] = d;
    endX();
  endtask

  task automatic readByte(input logic [6:0] a, input string tag);
    cmdOnly(8'h62, {1'b0, a}, 8'h00);
    dataBits(8'h00, 8, 1'b1, model[a], tag);
    dataBits(8'hFF, 8, 1'b0, 8'h00, "R7");
    endX();
  endtask

  initial begin
    repeat (2000000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 128; i++) model[i] = 8'h00;
    repeat (4) @(posedge clk);
    #1;
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    // R1: reset state
    chk(sdOe == 1'b0, "R1", "oe after reset", sdOe, 0);
    readByte(7'h33, "R1");
    readByte(7'h7F, "R1");

    // R5 / R6: single-byte writes and reads
    writeByte(7'h12, 8'hA5);
    writeByte(7'h7F, 8'h3C);
    writeByte(7'h00, 8'h81);
    readByte(7'h12, "R6");
    readByte(7'h7F, "R6");
    readByte(7'h00, "R6");

    // R7: extra clocks after a byte write
    cmdOnly(8'h9D, 8'h20, 8'h00);
    dataBits(8'h5A, 8, 1'b0, 8'h00, "R5");
    model[7'h20] = 8'h5A;
    dataBits(8'hFF, 16, 1'b0, 8'h00, "R7");
    endX();
    readByte(7'h20, "R7");
    readByte(7'h21, "R7");

    // R2: bad first byte, then would-be write data
    cmdOnly(8'h9C, 8'h12, 8'h00);
    dataBits(8'h00, 8, 1'b0, 8'h00, "R2");
    endX();
    readByte(7'h12, "R2");
    // R2: corrupted read code gives no drive
    cmdOnly(8'h63, 8'h12, 8'h00);
    dataBits(8'h00, 8, 1'b0, 8'h00, "R2");
    endX();

    // R3: address byte bit 7 set
    cmdOnly(8'h9D, 8'h92, 8'h00);
    dataBits(8'h00, 8, 1'b0, 8'h00, "R3");
    endX();
    readByte(7'h12, "R3");

    // R4: low bits of third byte set
    cmdOnly(8'h9D, 8'h12, 8'h01);
    dataBits(8'h00, 8, 1'b0, 8'h00, "R4");
    endX();
    cmdOnly(8'h62, 8'h12, 8'h40);
    dataBits(8'h00, 8, 1'b0, 8'h00, "R4");
    endX();
    readByte(7'h12, "R4");

    // R12: valid command after a lock in the same transfer
    cmdOnly(8'h00, 8'h12, 8'h00);
    dataBits(8'h9D, 8, 1'b0, 8'h00, "R12");
    dataBits(8'h12, 8, 1'b0, 8'h00, "R12");
    dataBits(8'h00, 8, 1'b0, 8'h00, "R12");
    dataBits(8'h00, 8, 1'b0, 8'h00, "R12");
    endX();
    readByte(7'h12, "R12");
    writeByte(7'h12, 8'h6E);
    readByte(7'h12, "R12");

    // R10: partial write byte discarded
    cmdOnly(8'h9D, 8'h12, 8'h00);
    dataBits(8'h01, 4, 1'b0, 8'h00, "R10");
    endX();
    readByte(7'h12, "R10");

    // R9: burst flag with nonzero address
    cmdOnly(8'h9D, 8'h05, 8'h80);
    dataBits(8'h77, 8, 1'b0, 8'h00, "R9");
    model[7'h05] = 8'h77;
    dataBits(8'h11, 8, 1'b0, 8'h00, "R9");
    endX();
    readByte(7'h05, "R9");
    readByte(7'h06, "R9");
    cmdOnly(8'h62, 8'h05, 8'h80);
    dataBits(8'h00, 8, 1'b1, model[7'h05], "R9");
    dataBits(8'h00, 8, 1'b0, 8'h00, "R9");
    endX();

    // R8: burst write then burst read of the whole array
    cmdOnly(8'h9D, 8'h00, 8'h80);
    for (int k = 0; k < 128; k++) begin
      logic [7:0] v;
      v = 8'((k * 37 + 11) & 255);
      dataBits(v, 8, 1'b0, 8'h00, "R8");
      model[k] = v;
    end
    dataBits(8'hFF, 8, 1'b0, 8'h00, "R8");
    endX();
    cmdOnly(8'h62, 8'h00, 8'h80);
    for (int k = 0; k < 128; k++) dataBits(8'h00, 8, 1'b1, model[k], "R8");
    dataBits(8'h00, 8, 1'b0, 8'h00, "R8");
    endX();
    readByte(7'h40, "R8");
    readByte(7'h00, "R8");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule